// File: doc/BRIEF.md
# Four-Lane Dual-Width Data Buffer

This block sits between a 32-bit register bus and a serial shift engine and holds the data that flows in both directions. Each direction owns a bank of four parallel byte FIFOs, 16 entries deep. A word access on the bus moves one byte through every lane at once, so a bank holds 64 bytes when driven by words. A byte access touches lane 0 only, so it holds 16 bytes when driven by bytes. The serial side moves one byte per handshake. In wide mode it walks the lanes in order 0, 1, 2, 3 and wraps. In narrow mode it stays on lane 0.

A set of sticky status bits reports the level of both banks, the end of a transfer, and bus accesses that cannot be honoured. The status register, an interrupt enable register and a write-one-to-clear register are separate. A single interrupt output is raised while any enabled status bit is set.

Bus address map (3-bit `bus_addr`): 0 TX word write, 1 TX byte write, 2 RX word read, 3 RX byte read, 4 status (read only), 5 interrupt enable (read/write), 6 clear (write 1 to clear, reads 0). Address 7 is unused.

Top module: `quad_lane_fifo`

## Requirements
- R1: A word write to address 0 places bits 7:0 in lane 0, 15:8 in lane 1, 23:16 in lane 2 and 31:24 in lane 3. With `wide_mode`=1 the serial side delivers the bytes in lane order 0,1,2,3 and then wraps.
- R2: A byte write to address 1 stores `bus_wdata[7:0]` in lane 0 only. With `wide_mode`=0 the serial side drains lane 0 only.
- R3: The TX bank accepts 16 word writes (64 bytes) in wide mode and 16 byte writes in narrow mode. A further write is refused: it sets status bit 12, and the stored data stays intact and in order.
- R4: In wide mode serial RX bytes fill lanes 0,1,2,3 in turn. A word read at address 2 returns {lane3,lane2,lane1,lane0}. A byte read at address 3 returns lane 0 in bits 7:0 with the upper bits zero.
- R5: A word read while any RX lane is empty, or a byte read while lane 0 is empty, returns 0. It sets status bit 12 and removes nothing.
- R6: The TX flags are: empty at bit 1, half-full at bit 2, full at bit 3, and trigger at bit 0. Half-full means 32 or more bytes in total in wide mode, or 8 or more in lane 0 in narrow mode. Full means any lane full in wide mode, or lane 0 full in narrow mode. Trigger means the lane 0 count is at or below `TX_TRIG`.
- R7: The RX flags are: trigger at bit 5 (lane 0 count at or above `RX_TRIG`), word-available at bit 6 (every lane non-empty), half-full at bit 7, full at bit 8, and byte-available at bit 11 (lane 0 non-empty). Half-full and full use the same mode rules as TX.
- R8: Status bits are sticky and stay set after their condition goes away, until a 1 is written to that bit at address 6. A cleared bit whose condition still holds reads 1 again.
- R9: A pulse on `xfer_done` sets status bit 9.
- R10: `irq` is the OR of status AND enable. After reset the enable register holds only bit 12 (0x1000).
- R11: A write to address 2, 3 or 4, a read from address 0 or 1, or any access to address 7 sets status bit 12 and changes no other state.
- R12: After reset both banks are empty. `tx_ser_valid` is 0, `rx_ser_ready` is 1, and status shows only TX empty and TX trigger (0x0003).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1: serial side walks all four lanes; 0: lane 0 only |
| bus_req | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Register/port select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| tx_ser_valid | output | 1 | TX byte available on the current lane |
| tx_ser_pop | input | 1 | Serial side takes the TX byte |
| tx_ser_data | output | 8 | TX byte at the current lane head |
| rx_ser_ready | output | 1 | Current RX lane has room |
| rx_ser_push | input | 1 | Serial side delivers an RX byte |
| rx_ser_data | input | 8 | RX byte |
| xfer_done | input | 1 | End-of-transfer pulse |
| irq | output | 1 | Interrupt |

## Verification
Read data and the serial outputs are combinational from the FIFO heads, so they are due in the same cycle as the access. An access commits at the next rising edge. An illegal access sets its status bit at that same edge. A level flag that follows a FIFO change appears one edge later, because the counts are registered before the flags are sampled. Every bench operation takes two cycles: it drives at a falling edge, samples just before the committing edge, and then idles for a cycle. A status read that follows any access therefore always lands after both edges. Interrupt checks sample at the falling edge after a clear or enable write has committed.

// File: rtl/qlf_pkg.sv
package qlf_pkg;
  // bus port / register select
  localparam logic [2:0] ADDR_TX_WORD = 3'd0;
  localparam logic [2:0] ADDR_TX_BYTE = 3'd1;
  localparam logic [2:0] ADDR_RX_WORD = 3'd2;
  localparam logic [2:0] ADDR_RX_BYTE = 3'd3;
  localparam logic [2:0] ADDR_STATUS  = 3'd4;
  localparam logic [2:0] ADDR_ENABLE  = 3'd5;
  localparam logic [2:0] ADDR_CLEAR   = 3'd6;

  // status bit positions (decoded by software, so fixed)
  localparam int BIT_TX_TRIG  = 0;
  localparam int BIT_TX_EMPTY = 1;
  localparam int BIT_TX_HALF  = 2;
  localparam int BIT_TX_FULL  = 3;
  localparam int BIT_RX_TRIG  = 5;
  localparam int BIT_RX_WORD  = 6;
  localparam int BIT_RX_HALF  = 7;
  localparam int BIT_RX_FULL  = 8;
  localparam int BIT_DONE     = 9;
  localparam int BIT_RX_BYTE  = 11;
  localparam int BIT_ILLEGAL  = 12;

  localparam logic [31:0] STATUS_MASK = 32'h0000_1BEF;
  localparam logic [31:0] ENABLE_RST  = 32'h0000_1000;
endpackage

// File: rtl/qlf_lane_fifo.sv
module qlf_lane_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_i,
  input  logic [DW-1:0]                wdata_i,
  input  logic                         pop_i,
  output logic [DW-1:0]                head_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (push_i) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop_i)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    case ({push_i, pop_i})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_q] <= wdata_i;
  end

  assign head_o  = mem[rd_q];
  assign count_o = cnt_q;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (cnt_q < CW'(DEPTH)));

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (cnt_q != '0));
endmodule

// File: rtl/qlf_lane_bank.sv
module qlf_lane_bank #(
  parameter int LANES = 4,
  parameter int DEPTH = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wide_i,
  input  logic                               push_all_i,
  input  logic [LANES*8-1:0]                 wdata_i,
  input  logic                               push_one_i,
  input  logic [((LANES>1)?$clog2(LANES):1)-1:0] push_lane_i,
  input  logic [7:0]                         byte_i,
  input  logic                               pop_all_i,
  input  logic                               pop_one_i,
  input  logic [((LANES>1)?$clog2(LANES):1)-1:0] pop_lane_i,
  output logic [LANES*8-1:0]                 head_o,
  output logic [LANES-1:0]                   lane_full_o,
  output logic [LANES-1:0]                   lane_empty_o,
  output logic [$clog2(DEPTH+1)-1:0]         cnt0_o,
  output logic                               full_o,
  output logic                               half_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(LANES * DEPTH + 1);

  logic [CW-1:0] cnt [LANES];
  logic [TW-1:0] total;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic push_l, pop_l;
    assign push_l = push_all_i | (push_one_i && (push_lane_i == l));
    assign pop_l  = pop_all_i  | (pop_one_i  && (pop_lane_i  == l));

    qlf_lane_fifo #(.DW(8), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push_l),
      .wdata_i (push_all_i ? wdata_i[l*8 +: 8] : byte_i),
      .pop_i   (pop_l),
      .head_o  (head_o[l*8 +: 8]),
      .count_o (cnt[l])
    );

    assign lane_full_o[l]  = (cnt[l] == CW'(DEPTH));
    assign lane_empty_o[l] = (cnt[l] == '0);
  end

  always_comb begin
    total = '0;
    for (int l = 0; l < LANES; l++) total = total + TW'(cnt[l]);
  end

  assign cnt0_o = cnt[0];
  assign full_o = wide_i ? (|lane_full_o) : lane_full_o[0];
  assign half_o = wide_i ? (total >= TW'(LANES * DEPTH / 2))
                         : (cnt[0] >= CW'(DEPTH / 2));
endmodule

// File: rtl/qlf_lane_cursor.sv
module qlf_lane_cursor #(
  parameter int LANES = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wide_i,
  input  logic                                   step_i,
  output logic [((LANES>1)?$clog2(LANES):1)-1:0] lane_o
);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LW-1:0] lane_q, lane_d;

  always_comb begin
    lane_d = lane_q;
    if (!wide_i)     lane_d = '0;
    else if (step_i) lane_d = (lane_q == LW'(LANES - 1)) ? '0 : lane_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane_q <= '0;
    else        lane_q <= lane_d;
  end

  assign lane_o = lane_q;

  // R1
  lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_i && step_i && lane_q != LW'(LANES - 1)) |=> (lane_q == $past(lane_q) + 1'b1));
endmodule

// File: rtl/qlf_status_regs.sv
module qlf_status_regs #(
  parameter int          W      = 32,
  parameter logic [W-1:0] MASK  = '1,
  parameter logic [W-1:0] EN_RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic         en_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] enable_o,
  output logic         irq_o
);
  logic [W-1:0] st_q, st_d, en_q, en_d, clr;

  always_comb begin
    clr  = clr_we_i ? wdata_i : '0;
    st_d = ((st_q & ~clr) | set_i) & MASK;
    en_d = en_we_i ? (wdata_i & MASK) : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= EN_RST;
    end else begin
      st_q <= st_d;
      en_q <= en_d;
    end
  end

  assign status_o = st_q;
  assign enable_o = en_q;
  assign irq_o    = |(st_q & en_q);

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & $past(st_q & ~clr)) == $past(st_q & ~clr)));
endmodule

// File: rtl/quad_lane_fifo.sv
module quad_lane_fifo #(
  parameter int LANES   = 4,
  parameter int DEPTH   = 16,
  parameter int TX_TRIG = 4,
  parameter int RX_TRIG = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wide_mode,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tx_ser_valid,
  input  logic        tx_ser_pop,
  output logic [7:0]  tx_ser_data,
  output logic        rx_ser_ready,
  input  logic        rx_ser_push,
  input  logic [7:0]  rx_ser_data,
  input  logic        xfer_done,
  output logic        irq
);
  import qlf_pkg::*;

  localparam int BUS_W = LANES * 8;
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int CW    = $clog2(DEPTH + 1);

  logic             rd, wr;
  logic             tx_push_all, tx_push_one, tx_pop_one;
  logic             rx_push_one, rx_pop_all, rx_pop_one;
  logic             illegal, en_we, clr_we;
  logic [LW-1:0]    tx_cur, rx_cur;
  logic [BUS_W-1:0] tx_head, rx_head;
  logic [LANES-1:0] tx_lfull, tx_lempty, rx_lfull, rx_lempty;
  logic [CW-1:0]    tx_cnt0, rx_cnt0;
  logic             tx_full, tx_half, rx_full, rx_half, tx_empty;
  logic             tx_room, rx_avail;
  logic [31:0]      status, enable, set_vec;

  assign rd = bus_req & ~bus_we;
  assign wr = bus_req &  bus_we;

  assign tx_room  = ~|tx_lfull;
  assign rx_avail = ~|rx_lempty;
  assign tx_empty = wide_mode ? (&tx_lempty) : tx_lempty[0];

  // serial side
  assign tx_ser_valid = ~tx_lempty[tx_cur];
  assign tx_ser_data  = tx_head[tx_cur*8 +: 8];
  assign tx_pop_one   = tx_ser_pop & tx_ser_valid;
  assign rx_ser_ready = ~rx_lfull[rx_cur];
  assign rx_push_one  = rx_ser_push & rx_ser_ready;

  // bus decode
  always_comb begin
    tx_push_all = 1'b0;
    tx_push_one = 1'b0;
    rx_pop_all  = 1'b0;
    rx_pop_one  = 1'b0;
    en_we       = 1'b0;
    clr_we      = 1'b0;
    illegal     = 1'b0;
    bus_rdata   = '0;
    if (bus_req) begin
      case (bus_addr)
        ADDR_TX_WORD: begin
          if (wr && tx_room) tx_push_all = 1'b1;
          else               illegal     = 1'b1;
        end
        ADDR_TX_BYTE: begin
          if (wr && !tx_lfull[0]) tx_push_one = 1'b1;
          else                    illegal     = 1'b1;
        end
        ADDR_RX_WORD: begin
          if (rd && rx_avail) begin
            rx_pop_all = 1'b1;
            bus_rdata  = 32'(rx_head);
          end else illegal = 1'b1;
        end
        ADDR_RX_BYTE: begin
          if (rd && !rx_lempty[0]) begin
            rx_pop_one = 1'b1;
            bus_rdata  = {24'h0, rx_head[7:0]};
          end else illegal = 1'b1;
        end
        ADDR_STATUS: begin
          if (rd) bus_rdata = status;
          else    illegal   = 1'b1;
        end
        ADDR_ENABLE: begin
          if (rd) bus_rdata = enable;
          else    en_we     = 1'b1;
        end
        ADDR_CLEAR: begin
          if (wr) clr_we = 1'b1;
        end
        default: illegal = 1'b1;
      endcase
    end
  end

  // status conditions
  always_comb begin
    set_vec               = '0;
    set_vec[BIT_TX_TRIG]  = (tx_cnt0 <= CW'(TX_TRIG));
    set_vec[BIT_TX_EMPTY] = tx_empty;
    set_vec[BIT_TX_HALF]  = tx_half;
    set_vec[BIT_TX_FULL]  = tx_full;
    set_vec[BIT_RX_TRIG]  = (rx_cnt0 >= CW'(RX_TRIG));
    set_vec[BIT_RX_WORD]  = rx_avail;
    set_vec[BIT_RX_HALF]  = rx_half;
    set_vec[BIT_RX_FULL]  = rx_full;
    set_vec[BIT_DONE]     = xfer_done;
    set_vec[BIT_RX_BYTE]  = ~rx_lempty[0];
    set_vec[BIT_ILLEGAL]  = illegal;
  end

  qlf_lane_cursor #(.LANES(LANES)) u_tx_cur (
    .clk (clk), .rst_n (rst_n), .wide_i (wide_mode),
    .step_i (tx_pop_one), .lane_o (tx_cur)
  );

  qlf_lane_cursor #(.LANES(LANES)) u_rx_cur (
    .clk (clk), .rst_n (rst_n), .wide_i (wide_mode),
    .step_i (rx_push_one), .lane_o (rx_cur)
  );

  qlf_lane_bank #(.LANES(LANES), .DEPTH(DEPTH)) u_tx_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .wide_i       (wide_mode),
    .push_all_i   (tx_push_all),
    .wdata_i      (bus_wdata[BUS_W-1:0]),
    .push_one_i   (tx_push_one),
    .push_lane_i  ('0),
    .byte_i       (bus_wdata[7:0]),
    .pop_all_i    (1'b0),
    .pop_one_i    (tx_pop_one),
    .pop_lane_i   (tx_cur),
    .head_o       (tx_head),
    .lane_full_o  (tx_lfull),
    .lane_empty_o (tx_lempty),
    .cnt0_o       (tx_cnt0),
    .full_o       (tx_full),
    .half_o       (tx_half)
  );

  qlf_lane_bank #(.LANES(LANES), .DEPTH(DEPTH)) u_rx_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .wide_i       (wide_mode),
    .push_all_i   (1'b0),
    .wdata_i      ('0),
    .push_one_i   (rx_push_one),
    .push_lane_i  (rx_cur),
    .byte_i       (rx_ser_data),
    .pop_all_i    (rx_pop_all),
    .pop_one_i    (rx_pop_one),
    .pop_lane_i   ('0),
    .head_o       (rx_head),
    .lane_full_o  (rx_lfull),
    .lane_empty_o (rx_lempty),
    .cnt0_o       (rx_cnt0),
    .full_o       (rx_full),
    .half_o       (rx_half)
  );

  qlf_status_regs #(.W(32), .MASK(STATUS_MASK), .EN_RST(ENABLE_RST)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_vec),
    .clr_we_i (clr_we),
    .en_we_i  (en_we),
    .wdata_i  (bus_wdata),
    .status_o (status),
    .enable_o (enable),
    .irq_o    (irq)
  );

  // R11
  illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> status[BIT_ILLEGAL]);

  // R9
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> status[BIT_DONE]);

  // R3
  refused_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == ADDR_TX_WORD && !tx_room) |-> !tx_push_all);
endmodule

// File: tb/quad_lane_fifo_tb.sv
module quad_lane_fifo_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wide_mode, bus_req, bus_we;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        tx_ser_valid, tx_ser_pop, rx_ser_ready, rx_ser_push;
  logic [7:0]  tx_ser_data, rx_ser_data;
  logic        xfer_done, irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_lane_fifo u_dut (
    .clk (clk), .rst_n (rst_n), .wide_mode (wide_mode),
    .bus_req (bus_req), .bus_we (bus_we), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .tx_ser_valid (tx_ser_valid), .tx_ser_pop (tx_ser_pop), .tx_ser_data (tx_ser_data),
    .rx_ser_ready (rx_ser_ready), .rx_ser_push (rx_ser_push), .rx_ser_data (rx_ser_data),
    .xfer_done (xfer_done), .irq (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic ser_pop(output logic [7:0] b, output logic v);
    @(negedge clk);
    v = tx_ser_valid; b = tx_ser_data; tx_ser_pop = 1'b1;
    @(negedge clk);
    tx_ser_pop = 1'b0;
  endtask

  task automatic ser_push(input logic [7:0] b);
    @(negedge clk);
    rx_ser_push = 1'b1; rx_ser_data = b;
    @(negedge clk);
    rx_ser_push = 1'b0;
  endtask

  task automatic stat_bit(input string req, input int b, input logic exp);
    logic [31:0] d;
    bus_rd(3'd4, d);
    chk(req, 32'(d[b]), 32'(exp));
  endtask

  task automatic clear_all();
    bus_wr(3'd6, 32'h1FFF);
  endtask

  task automatic set_wide(input logic w);
    @(negedge clk);
    wide_mode = w;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R12 tx_ser_valid", 32'(tx_ser_valid), 0);
    chk("R12 rx_ser_ready", 32'(rx_ser_ready), 1);
    chk("R10 irq after reset", 32'(irq), 0);
    bus_rd(3'd5, d); chk("R10 enable reset", d, 32'h1000);
    bus_rd(3'd4, d); chk("R12 status reset", d, 32'h0003);
  endtask

  task automatic t_wide_tx();
    logic [7:0] b; logic v;
    set_wide(1'b1);
    bus_wr(3'd0, 32'h4433_2211);
    bus_wr(3'd0, 32'h8877_6655);
    for (int i = 0; i < 8; i++) begin
      ser_pop(b, v);
      chk("R1 valid", 32'(v), 1);
      chk("R1 byte order", 32'(b), 32'(8'h11 * (i + 1)));
    end
    chk("R1 drained", 32'(tx_ser_valid), 0);
  endtask

  task automatic t_narrow_tx();
    logic [7:0] b; logic v;
    set_wide(1'b0);
    bus_wr(3'd1, 32'hFFFF_FFA1);
    bus_wr(3'd1, 32'h0000_12B2);
    ser_pop(b, v); chk("R2 first byte", 32'(b), 32'hA1);
    ser_pop(b, v); chk("R2 second byte", 32'(b), 32'hB2);
    chk("R2 drained", 32'(tx_ser_valid), 0);
  endtask

  task automatic t_capacity();
    logic [7:0] b; logic v; logic [31:0] d;
    set_wide(1'b1);
    clear_all();
    for (int w = 0; w < 16; w++)
      bus_wr(3'd0, {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)});
    stat_bit("R3 no illegal at 64 bytes", 12, 1'b0);
    bus_wr(3'd6, 32'h0003);
    bus_rd(3'd4, d);
    chk("R6 tx trigger clear above level", 32'(d[0]), 0);
    chk("R6 tx not empty", 32'(d[1]), 0);
    chk("R6 tx half wide", 32'(d[2]), 1);
    chk("R6 tx full wide", 32'(d[3]), 1);
    bus_wr(3'd0, 32'hDEAD_BEEF);
    stat_bit("R3 overflow flagged", 12, 1'b1);
    for (int i = 0; i < 64; i++) begin
      ser_pop(b, v);
      if (b !== 8'(i) || !v) chk("R3 wide contents", {23'h0, v, b}, {24'h1, 8'(i)});
    end
    chk("R3 wide drained", 32'(tx_ser_valid), 0);
    set_wide(1'b0);
    clear_all();
    for (int i = 0; i < 16; i++) bus_wr(3'd1, 32'(8'h40 + i));
    stat_bit("R6 tx full narrow", 3, 1'b1);
    bus_wr(3'd1, 32'h0000_00EE);
    stat_bit("R3 narrow overflow flagged", 12, 1'b1);
    for (int i = 0; i < 16; i++) begin
      ser_pop(b, v);
      if (b !== 8'(8'h40 + i)) chk("R3 narrow contents", 32'(b), 32'(8'h40 + i));
    end
    chk("R3 narrow drained", 32'(tx_ser_valid), 0);
  endtask

  task automatic t_wide_rx();
    logic [31:0] d;
    set_wide(1'b1);
    for (int i = 0; i < 8; i++) ser_push(8'(8'h10 + i));
    bus_rd(3'd2, d); chk("R4 word read 0", d, 32'h1312_1110);
    bus_rd(3'd2, d); chk("R4 word read 1", d, 32'h1716_1514);
    set_wide(1'b0);
    ser_push(8'h5A);
    bus_rd(3'd3, d); chk("R4 byte read", d, 32'h0000_005A);
  endtask

  task automatic t_empty_rx();
    logic [31:0] d;
    clear_all();
    bus_rd(3'd2, d); chk("R5 empty word read data", d, 0);
    stat_bit("R5 empty word read flagged", 12, 1'b1);
    ser_push(8'h77);
    bus_rd(3'd2, d); chk("R5 partial word read data", d, 0);
    bus_rd(3'd3, d); chk("R5 byte kept", d, 32'h77);
  endtask

  task automatic t_rx_flags();
    logic [31:0] d;
    clear_all();
    for (int i = 0; i < 16; i++) ser_push(8'(8'h80 + i));
    chk("R7 rx ready low when full", 32'(rx_ser_ready), 0);
    bus_rd(3'd4, d);
    chk("R7 rx trigger", 32'(d[5]), 1);
    chk("R7 rx word-available", 32'(d[6]), 0);
    chk("R7 rx half", 32'(d[7]), 1);
    chk("R7 rx full", 32'(d[8]), 1);
    chk("R7 rx byte-available", 32'(d[11]), 1);
    for (int i = 0; i < 16; i++) begin
      bus_rd(3'd3, d);
      if (d !== 32'(8'h80 + i)) chk("R7 rx contents", d, 32'(8'h80 + i));
    end
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    clear_all();
    ser_push(8'h31);
    bus_rd(3'd3, d); chk("R8 byte", d, 32'h31);
    stat_bit("R8 byte-available held", 11, 1'b1);
    bus_wr(3'd6, 32'h0800);
    stat_bit("R8 cleared bit", 11, 1'b0);
    bus_wr(3'd6, 32'h0002);
    stat_bit("R8 live condition resets bit", 1, 1'b1);
  endtask

  task automatic t_done();
    clear_all();
    stat_bit("R9 done clear", 9, 1'b0);
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    stat_bit("R9 done set", 9, 1'b1);
  endtask

  task automatic t_irq();
    clear_all();
    bus_wr(3'd5, 32'h0200);
    chk("R10 masked", 32'(irq), 0);
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    chk("R10 irq on enabled bit", 32'(irq), 1);
    bus_wr(3'd6, 32'h0200);
    chk("R10 irq after clear", 32'(irq), 0);
    bus_wr(3'd5, 32'h0002);
    chk("R10 irq tx empty enabled", 32'(irq), 1);
    bus_wr(3'd5, 32'h1000);
  endtask

  task automatic t_illegal();
    logic [31:0] d;
    clear_all();
    bus_wr(3'd4, 32'hFFFF_FFFF);
    stat_bit("R11 write status", 12, 1'b1);
    bus_rd(3'd5, d); chk("R11 enable untouched", d, 32'h1000);
    bus_wr(3'd6, 32'h1000);
    stat_bit("R11 cleared", 12, 1'b0);
    bus_rd(3'd0, d);
    stat_bit("R11 read tx port", 12, 1'b1);
    chk("R11 tx still empty", 32'(tx_ser_valid), 0);
    bus_wr(3'd6, 32'h1000);
    bus_wr(3'd7, 32'h0);
    stat_bit("R11 unused address", 12, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; wide_mode = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0; tx_ser_pop = 1'b0; rx_ser_push = 1'b0;
    rx_ser_data = '0; xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_wide_tx();
    t_narrow_tx();
    t_capacity();
    t_wide_rx();
    t_empty_rx();
    t_rx_flags();
    t_sticky();
    t_done();
    t_irq();
    t_illegal();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule